// File: doc/BRIEF.md
# Double-Threshold Hit Qualifier and Gate Generator

This block turns pairs of digitised comparator outputs into hit triggers and fixed-length gates. Each channel has a sensitive comparator input (low threshold) and a noise-rejecting comparator input (high threshold). The sensitive signal passes through a delay line of programmable length. A hit is accepted when the delayed sensitive signal and the high-threshold signal are both asserted. Because the sensitive edge arrives late, the high-threshold signal is normally already present when it does. The accepted hit then carries the timing of the low-threshold crossing, while the high-threshold input decides whether the hit counts at all. Noise that crosses only the low threshold never opens a gate.

Each accepted hit produces a one-cycle trigger pulse and starts a one-shot gate that lasts a fixed number of clock cycles. While a gate is open, new hits on that channel are dropped and are not stored for later. A single pedestal-request input is shared by all channels. Its rising edge opens the gate of every idle channel with no comparator activity, so that baseline data can be taken. Delay and gate length are parameters in clock cycles, and the whole block runs on one sampling clock with a synchronous active-high reset.

Top module: `dt_trig_gen`

## Requirements
- R1: With the high-threshold input already high, a rise of the low-threshold input sampled at clock edge k makes trig_o and gate_o rise together right after edge k+DELAY_CYC.
- R2: A hit needs both inputs. A low-threshold signal alone or a high-threshold signal alone, held for any length of time, never raises trig_o or gate_o.
- R3: If the high-threshold input rises no later than the delayed low-threshold signal, the trigger time depends only on the low-threshold rise. If the high-threshold input rises after the delayed low-threshold signal, the trigger follows the high-threshold rise by one cycle.
- R4: Every gate stays high for exactly GATE_CYC consecutive cycles, unless a reset cuts it short.
- R5: trig_o is high for exactly one cycle per accepted hit, in the first cycle of the gate. It is never high in any other cycle.
- R6: A coincidence rise while the channel's gate is high, including its last cycle, is ignored and is not held for later. A coincidence rise in the first cycle after the gate ends starts a new gate at once.
- R7: Only a rising edge of the coincidence fires. A coincidence that stays high does not fire again after the gate closes.
- R8: A rise of ped_req_i seen during cycle p opens the gate of every idle channel from cycle p+1, with trig_o left low.
- R9: ped_req_i has no effect on a channel whose gate is already open. Holding ped_req_i high does not fire again after the gates close.
- R10: Reset clears all gates, triggers and delay-line contents. After reset is released, a hit needs a full DELAY_CYC of low-threshold history before it can fire.
- R11: While reset is applied, and right after it, all trig_o and gate_o bits are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock |
| rst_i | input | 1 | Synchronous reset, active high |
| lo_hit_i | input | NUM_CH | Low-threshold comparator outputs, one per channel |
| hi_hit_i | input | NUM_CH | High-threshold comparator outputs, one per channel |
| ped_req_i | input | 1 | Shared pedestal request; a rising edge opens all idle gates |
| trig_o | output | NUM_CH | One-cycle trigger pulse per accepted hit |
| gate_o | output | NUM_CH | Fixed-length gate per channel |

## Verification
The hardest conditions to reach from the ports are coincidence rises that land exactly on the last cycle of an open gate, or exactly on the first idle cycle after it. Reaching them takes cycle-exact timing of the high-threshold input relative to a gate whose start already includes the full delay. The stimulus holds the low-threshold input high so the delayed signal is settled. It then toggles only the high-threshold input at absolute cycle numbers computed from the expected gate start, so the coincidence edge falls on a chosen cycle. A similar arrangement asserts reset while a gate is open with both inputs still held high. This shows that the refilled delay line, not stale contents, sets the next trigger time.

// File: rtl/dt_trig_pkg.sv
package dt_trig_pkg;

    // Which request opened the current gate of a channel.
    typedef enum logic [1:0] {
        SRC_IDLE = 2'd0,
        SRC_HIT  = 2'd1,
        SRC_PED  = 2'd2
    } fire_src_e;

    // A qualified hit takes precedence over a pedestal request in the same cycle.
    function automatic fire_src_e pick_source(input logic hit, input logic ped);
        if (hit) begin
            return SRC_HIT;
        end else if (ped) begin
            return SRC_PED;
        end
        return SRC_IDLE;
    endfunction

endpackage

// File: rtl/dt_delay_line.sv
module dt_delay_line #(
    parameter int DEPTH = 20
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic sig_i,
    output logic sig_o
);
    localparam int W = (DEPTH < 1) ? 1 : DEPTH;

    typedef struct packed {
        logic [W-1:0] taps;
    } dl_state_t;

    dl_state_t st_d, st_q;

    generate
        if (W == 1) begin : g_single
            always_comb begin
                st_d      = st_q;
                st_d.taps = sig_i;
            end
        end else begin : g_chain
            always_comb begin
                st_d      = st_q;
                st_d.taps = {st_q.taps[W-2:0], sig_i};
            end
        end
    endgenerate

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sig_o = st_q.taps[W-1];

    // R1: the output follows the input exactly W sampling edges later; check the first stage.
    a_r1_first_tap: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> (st_q.taps[0] == $past(sig_i)));

    // R10: a reset leaves the whole line empty.
    a_r10_line_clear: assert property (@(posedge clk_i)
        rst_i |=> (st_q.taps == '0));

endmodule

// File: rtl/dt_oneshot.sv
module dt_oneshot
    import dt_trig_pkg::*;
#(
    parameter int GATE_CYC = 850
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic hit_fire_i,
    input  logic ped_fire_i,
    output logic trig_o,
    output logic gate_o
);
    localparam int LEN = (GATE_CYC < 1) ? 1 : GATE_CYC;
    localparam int CW  = $clog2(LEN + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        fire_src_e     src;
        logic          trig;
    } os_state_t;

    os_state_t st_d, st_q;
    logic      busy;
    logic      start;
    fire_src_e req_src;

    always_comb begin
        st_d    = st_q;
        busy    = (st_q.cnt != '0);
        req_src = pick_source(hit_fire_i, ped_fire_i);
        start   = !busy && (req_src != SRC_IDLE);

        if (start) begin
            st_d.cnt = CW'(LEN);
            st_d.src = req_src;
        end else if (busy) begin
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.src = SRC_IDLE;
            end
        end else begin
            st_d.src = SRC_IDLE;
        end
        st_d.trig = start && (req_src == SRC_HIT);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{cnt: '0, src: SRC_IDLE, trig: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o = st_q.trig;
    assign gate_o = (st_q.cnt != '0);

    // R5: the trigger pulse lasts one cycle.
    a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i)
        trig_o |=> !trig_o);

    // R6: an open gate keeps counting down whatever requests arrive.
    a_r6_no_restart: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.cnt > CW'(1)) |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)));

    // R8: a pedestal request reaching an idle channel opens its gate.
    a_r8_ped_opens: assert property (@(posedge clk_i) disable iff (rst_i)
        (ped_fire_i && !gate_o) |=> gate_o);

    // R8: a gate opened by a pedestal request never carries a trigger.
    a_r8_ped_silent: assert property (@(posedge clk_i) disable iff (rst_i)
        (st_q.src == SRC_PED) |-> !trig_o);

    // R11: reset leaves every output low.
    a_r11_reset_low: assert property (@(posedge clk_i)
        rst_i |=> (!gate_o && !trig_o));

endmodule

// File: rtl/dt_channel.sv
module dt_channel #(
    parameter int DELAY_CYC = 20,
    parameter int GATE_CYC  = 850
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic lo_i,
    input  logic hi_i,
    input  logic ped_fire_i,
    output logic trig_o,
    output logic gate_o
);
    typedef struct packed {
        logic coin;
    } ch_state_t;

    ch_state_t st_d, st_q;
    logic      lo_late;
    logic      coin_now;
    logic      hit_edge;

    dt_delay_line #(
        .DEPTH (DELAY_CYC)
    ) i_delay (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .sig_i (lo_i),
        .sig_o (lo_late)
    );

    always_comb begin
        st_d      = st_q;
        coin_now  = lo_late && hi_i;
        hit_edge  = coin_now && !st_q.coin;
        st_d.coin = coin_now;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dt_oneshot #(
        .GATE_CYC (GATE_CYC)
    ) i_oneshot (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .hit_fire_i (hit_edge),
        .ped_fire_i (ped_fire_i),
        .trig_o     (trig_o),
        .gate_o     (gate_o)
    );

    // R2: a trigger needs both the delayed low-threshold signal and the high-threshold signal.
    a_r2_needs_both: assert property (@(posedge clk_i) disable iff (rst_i)
        trig_o |-> $past(lo_late && hi_i));

    // R7: a trigger follows a cycle in which the coincidence was low.
    a_r7_edge_only: assert property (@(posedge clk_i) disable iff (rst_i)
        trig_o |-> !$past(st_q.coin));

    // R6: a trigger is never issued while the previous gate is still open.
    a_r6_no_overlap: assert property (@(posedge clk_i) disable iff (rst_i)
        trig_o |-> !$past(gate_o));

endmodule

// File: rtl/dt_trig_gen.sv
module dt_trig_gen #(
    parameter int NUM_CH    = 32,
    parameter int DELAY_CYC = 20,
    parameter int GATE_CYC  = 850
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_CH-1:0] lo_hit_i,
    input  logic [NUM_CH-1:0] hi_hit_i,
    input  logic              ped_req_i,
    output logic [NUM_CH-1:0] trig_o,
    output logic [NUM_CH-1:0] gate_o
);
    typedef struct packed {
        logic ped;
    } top_state_t;

    top_state_t st_d, st_q;
    logic       ped_edge;

    always_comb begin
        st_d     = st_q;
        ped_edge = ped_req_i && !st_q.ped;
        st_d.ped = ped_req_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            dt_channel #(
                .DELAY_CYC (DELAY_CYC),
                .GATE_CYC  (GATE_CYC)
            ) i_ch (
                .clk_i      (clk_i),
                .rst_i      (rst_i),
                .lo_i       (lo_hit_i[c]),
                .hi_i       (hi_hit_i[c]),
                .ped_fire_i (ped_edge),
                .trig_o     (trig_o[c]),
                .gate_o     (gate_o[c])
            );
        end
    endgenerate

    // R9: a pedestal request held high acts only once.
    a_r9_ped_once: assert property (@(posedge clk_i) disable iff (rst_i)
        ped_edge |=> !ped_edge);

endmodule

// File: tb/test_dt_trig_gen.sv
module test_dt_trig_gen;
    localparam int N = 4;
    localparam int D = 5;
    localparam int G = 16;

    typedef struct {
        int ch;
        int cyc;
        bit trig;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] lo = '0;
    logic [N-1:0] hi = '0;
    logic         ped = 1'b0;
    logic [N-1:0] trig;
    logic [N-1:0] gate;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t expq[$];
    logic [N-1:0] prev_gate = '0;
    int   rise_cyc [N];

    dt_trig_gen #(
        .NUM_CH    (N),
        .DELAY_CYC (D),
        .GATE_CYC  (G)
    ) i_dt_trig_gen (
        .clk_i     (clk),
        .rst_i     (rst),
        .lo_hit_i  (lo),
        .hi_hit_i  (hi),
        .ped_req_i (ped),
        .trig_o    (trig),
        .gate_o    (gate)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string msg);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic push_exp(input int ch, input int c, input bit t);
        exp_t e;
        e.ch = ch;
        e.cyc = c;
        e.trig = t;
        expq.push_back(e);
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drained(input string req);
        check(expq.size() == 0, req,
              $sformatf("pending expected gates actual %0d expected 0", expq.size()));
        expq.delete();
    endtask

    // Monitor: compares every gate opening with the scoreboard and measures widths.
    always @(negedge clk) begin
        if (rst) begin
            prev_gate = '0;
        end else begin
            for (int c = 0; c < N; c++) begin
                if (gate[c] && !prev_gate[c]) begin
                    rise_cyc[c] = cyc;
                    if (expq.size() == 0) begin
                        check(1'b0, "R2", $sformatf("unexpected gate ch%0d cyc %0d actual 1 expected 0", c, cyc));
                    end else begin
                        exp_t e;
                        e = expq.pop_front();
                        check(e.ch == c && e.cyc == cyc, "R1/R3",
                              $sformatf("gate start actual ch%0d cyc %0d expected ch%0d cyc %0d",
                                        c, cyc, e.ch, e.cyc));
                        check(trig[c] == e.trig, "R5",
                              $sformatf("trig at gate start ch%0d actual %0b expected %0b",
                                        c, trig[c], e.trig));
                    end
                end
                if (!gate[c] && prev_gate[c]) begin
                    check(cyc - rise_cyc[c] == G, "R4",
                          $sformatf("gate width ch%0d actual %0d expected %0d", c, cyc - rise_cyc[c], G));
                end
                if (trig[c] && !(gate[c] && !prev_gate[c])) begin
                    check(1'b0, "R5", $sformatf("trig outside gate start ch%0d actual 1 expected 0", c));
                end
            end
            prev_gate = gate;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c0;
        int t;
        int t2;
        int h;
        int p;
        int r;

        // R11: reset state
        idle(3);
        check(trig == '0 && gate == '0, "R11",
              $sformatf("during reset trig %b gate %b expected 0", trig, gate));
        rst = 1'b0;
        idle(2);
        check(trig == '0 && gate == '0, "R11",
              $sformatf("after reset trig %b gate %b expected 0", trig, gate));

        // R1: both inputs rise together on ch0
        c0 = cyc;
        lo[0] = 1'b1;
        hi[0] = 1'b1;
        push_exp(0, c0 + D + 1, 1'b1);
        idle(D + G + 4);
        lo[0] = 1'b0;
        hi[0] = 1'b0;
        idle(D + 2);
        drained("R1");

        // R3: high threshold first, timing from low threshold (ch1)
        hi[1] = 1'b1;
        idle(3);
        c0 = cyc;
        lo[1] = 1'b1;
        push_exp(1, c0 + D + 1, 1'b1);
        idle(D + G + 4);
        lo[1] = 1'b0;
        hi[1] = 1'b0;
        idle(D + 2);
        drained("R3");

        // R3: high threshold rises inside the delay window (ch2)
        c0 = cyc;
        lo[2] = 1'b1;
        push_exp(2, c0 + D + 1, 1'b1);
        idle(2);
        hi[2] = 1'b1;
        idle(D + G + 4);
        lo[2] = 1'b0;
        hi[2] = 1'b0;
        idle(D + 2);
        drained("R3");

        // R3: high threshold rises after the delayed low signal (ch3)
        lo[3] = 1'b1;
        idle(D + 3);
        h = cyc;
        hi[3] = 1'b1;
        push_exp(3, h + 1, 1'b1);
        idle(G + 4);
        lo[3] = 1'b0;
        hi[3] = 1'b0;
        idle(D + 2);
        drained("R3");

        // R2: a single comparator never fires
        hi[0] = 1'b1;
        idle(30);
        check(gate[0] == 1'b0 && trig[0] == 1'b0, "R2",
              $sformatf("high only gate %0b expected 0", gate[0]));
        hi[0] = 1'b0;
        lo[0] = 1'b1;
        idle(30);
        check(gate[0] == 1'b0 && trig[0] == 1'b0, "R2",
              $sformatf("low only gate %0b expected 0", gate[0]));
        lo[0] = 1'b0;
        idle(D + 2);
        drained("R2");

        // R6/R7: rise on last gate cycle ignored, held coincidence does not refire
        c0 = cyc;
        lo[0] = 1'b1;
        hi[0] = 1'b1;
        t = c0 + D + 1;
        push_exp(0, t, 1'b1);
        wait_cyc(t + 2);
        hi[0] = 1'b0;
        wait_cyc(t + G - 1);
        hi[0] = 1'b1;
        idle(G + 6);
        check(gate[0] == 1'b0, "R6",
              $sformatf("rise on last gate cycle gate %0b expected 0", gate[0]));
        check(gate[0] == 1'b0, "R7",
              $sformatf("held coincidence refire gate %0b expected 0", gate[0]));
        drained("R6");

        // R6: rise on first idle cycle after a gate starts a new gate immediately
        hi[0] = 1'b0;
        idle(2);
        t2 = cyc + 1;
        hi[0] = 1'b1;
        push_exp(0, t2, 1'b1);
        wait_cyc(t2 + 2);
        hi[0] = 1'b0;
        wait_cyc(t2 + G);
        hi[0] = 1'b1;
        push_exp(0, t2 + G + 1, 1'b1);
        idle(G + 4);
        lo[0] = 1'b0;
        hi[0] = 1'b0;
        idle(D + 2);
        drained("R6");

        // R8/R9: pedestal opens all idle gates once, held high
        p = cyc;
        ped = 1'b1;
        for (int c = 0; c < N; c++) push_exp(c, p + 1, 1'b0);
        idle(3 * G);
        check(gate == '0, "R9",
              $sformatf("held pedestal gate %b expected 0", gate));
        ped = 1'b0;
        idle(2);
        drained("R8");

        // R9: pedestal ignored by a busy channel
        c0 = cyc;
        lo[1] = 1'b1;
        hi[1] = 1'b1;
        t = c0 + D + 1;
        push_exp(1, t, 1'b1);
        wait_cyc(t + 3);
        p = cyc;
        ped = 1'b1;
        for (int c = 0; c < N; c++) if (c != 1) push_exp(c, p + 1, 1'b0);
        idle(1);
        ped = 1'b0;
        wait_cyc(t + G);
        check(gate[1] == 1'b0, "R9",
              $sformatf("busy channel gate at %0d actual %0b expected 0", cyc, gate[1]));
        lo[1] = 1'b0;
        hi[1] = 1'b0;
        idle(G + D + 4);
        drained("R9");

        // R10: reset during an open gate clears gate and delay line
        c0 = cyc;
        lo[2] = 1'b1;
        hi[2] = 1'b1;
        t = c0 + D + 1;
        push_exp(2, t, 1'b1);
        wait_cyc(t + 3);
        rst = 1'b1;
        idle(2);
        check(gate == '0 && trig == '0, "R10",
              $sformatf("after reset gate %b trig %b expected 0", gate, trig));
        r = cyc;
        rst = 1'b0;
        push_exp(2, r + D + 1, 1'b1);
        idle(2);
        check(gate[2] == 1'b0, "R10",
              $sformatf("stale delay fired gate %0b expected 0", gate[2]));
        idle(D + G + 4);
        lo[2] = 1'b0;
        hi[2] = 1'b0;
        idle(D + 2);
        drained("R10");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule